// File: doc/BRIEF.md
# Bitfield Read-Modify-Write Engine

This unit performs one bitfield operation on a big-endian, byte-addressed memory. The field is given by a base byte address, a signed bit offset and a 5-bit length. The unit works out which bytes hold the field, which is between one and five of them. It reads those bytes one at a time through a byte-wide port into a 40-bit window. It then extracts, modifies or scans the field and, for the modifying operations, writes the touched bytes back. The caller receives an operation result and the original field, left-justified, which it can use to derive condition flags.

An operation starts with a one-cycle `start` pulse while the unit is idle. `busy` stays high until the single-cycle `done` pulse. `result` and `field` stay valid from `done` until the next accepted start.

Top module: `bitfield_rmw`

## Requirements
- R1: A length code of 1..31 selects that many bits, and a length code of 0 selects 32 bits.
- R2: The offset is a signed two's-complement bit count with floor semantics. The first byte is at `base_addr + floor(ofs/8)`, and the starting bit within that byte is `ofs mod 8` (always 0..7).
- R3: The span is N = (bit + len - 1)/8 + 1 bytes, which is 1 to 5. Exactly N read cycles are issued, at ascending addresses starting from the first byte. Memory outside the span is never touched.
- R4: Bit numbering is big-endian. Bit 0 of the span is the most significant bit of its lowest-addressed byte.
- R5: Opcode 0 returns the field zero-extended and opcode 1 returns it sign-extended from its top bit. Opcode 7 behaves as opcode 0.
- R6: Opcode 2 replaces the field with the low `len` bits of `ins_val`. Its result is those bits left-justified in 32 bits.
- R7: Opcodes 3, 4 and 5 invert, clear and set the field bits respectively. Their result is the original field left-justified. All other bits of the span keep their values.
- R8: Opcode 6 returns the offset plus the number of leading zeros in the field. It returns offset plus length when the field is all zero.
- R9: Opcodes 0, 1, 6 and 7 issue no write cycles. Opcodes 2 to 5 write each span byte exactly once, at ascending addresses. A read and a write never happen in the same cycle.
- R10: `done` is a one-cycle pulse. Counting from the clock edge that samples `start`, it comes 2N cycles later for read-only opcodes and 3N cycles later for modifying ones. `field` holds the original field left-justified.
- R11: A `start` pulse while `busy` is high is ignored and does not alter the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 3 | Operation code |
| base_addr | input | AW | Base byte address |
| bit_ofs | input | 32 | Signed bit offset |
| fld_len | input | 5 | Field length, 0 means 32 |
| ins_val | input | 32 | Value for insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| field | output | 32 | Original field, left-justified |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data byte, valid the cycle after `mem_rd` |

## Verification
Each byte costs two cycles to read, because the strobe comes first and the data lands one cycle later. Each byte costs one cycle to write. `done` is therefore due 2N or 3N cycles after the start edge, and N is derived from the offset and length alone. The bench counts cycles from the start edge on the falling clock edge, and it compares that count to the expected latency rather than just waiting for `done`. Results, the field, the write count and the memory image are compared only on the cycle where `done` is seen. A second start is injected one cycle into some operations to confirm it leaves the results unchanged.

// File: rtl/bitfield_rmw.sv
module bitfield_rmw #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   bit_ofs,
  input  logic [4:0]    fld_len,
  input  logic [31:0]   ins_val,
  output logic          busy,
  output logic          done,
  output logic [31:0]   result,
  output logic [31:0]   field,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int WW = 40;
  localparam logic [2:0] OP_EXTS = 3'd1, OP_INS = 3'd2, OP_CHG = 3'd3,
                         OP_CLR = 3'd4, OP_SET = 3'd5, OP_FFO = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_WR, S_FIN} st_t;

  st_t           st;
  logic [2:0]    op_q, bit_q, cnt, last_q;
  logic [5:0]    len_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   ofs_q, val_q;
  logic [WW-1:0] win, new_win;

  wire [5:0]  len_in    = {fld_len == 5'd0, fld_len};
  wire [31:0] ofs_bytes = $signed(bit_ofs) >>> 3;
  wire [5:0]  end_bit   = {3'b000, bit_ofs[2:0]} + len_in - 6'd1;
  wire        modify    = (op_q >= OP_INS) && (op_q <= OP_SET);
  wire [5:0]  lane_sh   = 6'd32 - {cnt, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      bit_q  <= '0;
      len_q  <= 6'd32;
      addr_q <= '0;
      ofs_q  <= '0;
      val_q  <= '0;
      last_q <= '0;
      cnt    <= '0;
      win    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          bit_q  <= bit_ofs[2:0];
          len_q  <= len_in;
          addr_q <= base_addr + ofs_bytes[AW-1:0];
          ofs_q  <= bit_ofs;
          val_q  <= ins_val;
          last_q <= end_bit[5:3];
          cnt    <= '0;
          win    <= '0;
          st     <= S_RD;
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          win <= win | ({32'b0, mem_rdata} << lane_sh);
          if (cnt == last_q) begin
            cnt <= '0;
            st  <= modify ? S_WR : S_FIN;
          end else begin
            cnt <= cnt + 3'd1;
            st  <= S_RD;
          end
        end
        S_WR: begin
          if (cnt == last_q) st <= S_FIN;
          else cnt <= cnt + 3'd1;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [WW-1:0] mask   = (~({WW{1'b1}} >> len_q)) >> bit_q;
  wire [WW-1:0] fsh    = (win & mask) << bit_q;
  wire [5:0]    rsh    = 6'd32 - len_q;
  wire [31:0]   extu   = field >> rsh;
  wire [31:0]   exts   = $signed(field) >>> rsh;
  wire [31:0]   ins_lj = val_q << rsh;
  wire [WW-1:0] ins_w  = ({ins_lj, 8'h00} >> bit_q) & mask;
  wire [WW-1:0] wsh    = new_win >> lane_sh;

  function automatic logic [5:0] lead0(input logic [31:0] x);
    logic [5:0] n;
    n = 6'd32;
    for (int i = 0; i < 32; i++)
      if (x[i]) n = 6'(31 - i);
    return n;
  endfunction

  wire [5:0]  zcnt = (field == 32'd0) ? len_q : lead0(field);
  wire [31:0] ffo  = ofs_q + {26'd0, zcnt};

  assign field = fsh[39:8];

  always_comb begin
    case (op_q)
      OP_INS:  new_win = (win & ~mask) | ins_w;
      OP_CHG:  new_win = win ^ mask;
      OP_CLR:  new_win = win & ~mask;
      OP_SET:  new_win = win | mask;
      default: new_win = win;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_EXTS:                result = exts;
      OP_INS:                 result = ins_lj;
      OP_CHG, OP_CLR, OP_SET: result = field;
      OP_FFO:                 result = ffo;
      default:                result = extu;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_addr  = addr_q + AW'(cnt);
  assign mem_wdata = wsh[7:0];

  p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q != 6'd0 && len_q <= 6'd32));

  p_span_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> last_q <= 3'd4);

  p_rw_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_ro_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> modify);

  p_wr_ascend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> mem_addr == $past(mem_addr) + AW'(1));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(addr_q) && $stable(len_q) && $stable(val_q)));
endmodule

// File: tb/bitfield_rmw_test.sv
module bitfield_rmw_test;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int BASE = 16;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]    op = '0;
  logic [AW-1:0] base_addr = AW'(BASE);
  logic [31:0]   bit_ofs = '0, ins_val = '0;
  logic [4:0]    fld_len = '0;
  logic          busy, done, mem_rd, mem_wr;
  logic [31:0]   result, field;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = '0;

  logic [7:0] mem [64];
  logic [7:0] img [64];
  logic [7:0] exp_mem [64];
  logic       do_fill = 1'b0;
  int         wr_cnt = 0;
  int         n_chk = 0, n_bad = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #(CLK_NS/2) clk = ~clk;

  bitfield_rmw #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
    .bit_ofs(bit_ofs), .fld_len(fld_len), .ins_val(ins_val), .busy(busy),
    .done(done), .result(result), .field(field), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (do_fill) begin
      for (int k = 0; k < 64; k++) mem[k] <= img[k];
      wr_cnt <= 0;
    end else begin
      if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
      if (mem_wr) begin
        mem[mem_addr[5:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rnd(output logic [31:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = seed;
  endtask

  task automatic run(input logic [2:0] o, input int ofs, input logic [4:0] l5, input bit poke);
    int L, bb, n, lat, p, first1, mism;
    logic [63:0] f, sx;
    logic [31:0] v, r, er, ef;
    logic b, nb;
    bit modi;
    string rtag;
    for (int k = 0; k < 64; k++) begin
      rnd(r);
      img[k] = r[7:0];
    end
    rnd(v);
    L = (l5 == 5'd0) ? 32 : int'(l5);
    f = '0;
    first1 = -1;
    for (int i = 0; i < L; i++) begin
      p = BASE * 8 + ofs + i;
      b = img[p >>> 3][7 - (p & 7)];
      f = {f[62:0], b};
      if (b && first1 < 0) first1 = i;
    end
    for (int k = 0; k < 64; k++) exp_mem[k] = img[k];
    modi = (o >= 3'd2) && (o <= 3'd5);
    for (int i = 0; i < L; i++) begin
      p = BASE * 8 + ofs + i;
      b = img[p >>> 3][7 - (p & 7)];
      case (o)
        3'd2:    nb = v[L - 1 - i];
        3'd3:    nb = ~b;
        3'd4:    nb = 1'b0;
        3'd5:    nb = 1'b1;
        default: nb = b;
      endcase
      exp_mem[p >>> 3][7 - (p & 7)] = nb;
    end
    ef = f[31:0] << (32 - L);
    sx = f;
    if (f[L - 1]) sx = f | (~64'd0 << L);
    case (o)
      3'd1: begin er = sx[31:0]; rtag = "R5 R1 signed"; end
      3'd2: begin er = v << (32 - L); rtag = "R6 R1 insert"; end
      3'd3, 3'd4, 3'd5: begin er = ef; rtag = "R7 R1 modify"; end
      3'd6: begin er = (first1 < 0) ? 32'(ofs + L) : 32'(ofs + first1); rtag = "R8 R1 scan"; end
      default: begin er = f[31:0]; rtag = "R5 R1 unsigned"; end
    endcase
    if (poke) rtag = {rtag, " R11"};
    bb = ofs & 7;
    n = (bb + L - 1) / 8 + 1;

    @(negedge clk) do_fill = 1'b1;
    @(negedge clk) do_fill = 1'b0;
    op = o; bit_ofs = ofs; fld_len = l5; ins_val = v; start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 1) begin
        start = 1'b1; op = ~o; bit_ofs = ofs + 5; fld_len = l5 + 5'd3; ins_val = ~v;
      end else start = 1'b0;
    end
    start = 1'b0;
    chk("R3 R10 latency", lat, modi ? 3 * n : 2 * n);
    chk(rtag, result, er);
    chk("R2 R4 field", field, ef);
    chk("R9 write count", wr_cnt, modi ? n : 0);
    mism = 0;
    for (int k = 0; k < 64; k++) if (mem[k] !== exp_mem[k]) mism++;
    chk("R7 R3 memory image", mism, 0);
  endtask

  initial begin
    #(CLK_NS * 195000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R9 reset read strobe", mem_rd, 0);
    chk("R9 reset write strobe", mem_wr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 8; o++)
      for (int ofs = -9; ofs <= 9; ofs++)
        for (int l = 0; l < 32; l++)
          run(3'(o), ofs, 5'(l), (l % 7) == 3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule